// File: doc/BRIEF.md
# Configuration Address Translating Bridge

This block sits between a CPU's memory-mapped bus and a configuration-space target. Software first loads a 32-bit selector word into an index register, then touches a data window. Each window access becomes exactly one configuration request on a simple request/response port. The configuration address is built from the selector word and the low three bits of the window offset, using one of three decoding modes:

- **Pass-through:** the selector is used almost unchanged.
- **Type-1 style:** the selector's low bits are replaced by the offset.
- **One-hot slot:** the position of the lowest set slot bit is turned into a binary device number.

The data window is little-endian. Write data comes in right-justified and is moved onto the byte lanes picked by the offset. Read data is taken from those lanes and returned right-justified. The CPU access is acknowledged only after the response has arrived.

The block also routes the four interrupt pins of each device slot onto four consecutive inputs of an interrupt controller, rotating them by the device number.

Top module: `cfg_xlate_bridge`

## Requirements
- R1: After reset the selector register reads 0x00000000. An index write updates only the bytes its size and offset select. An index read returns the selector shifted right by 8×offset[1:0] and masked to the access size.
- R2: When selector bit 31 is 1, the configuration address is the selector with offset bits 1:0 ORed into its bits 1:0.
- R3: When selector bit 31 is 0 and bit 0 is 1, the configuration address is selector bits 31:3 followed by offset bits 2:0.
- R4: When selector bits 31 and 0 are both 0, the address is built as follows:
  - bits 31:16 are zero;
  - bits 15:11 hold the position of the lowest set selector bit in 31..11;
  - bits 10:3 copy selector bits 10:3;
  - bits 2:0 are offset bits 2:0.
- R5: In the one-hot mode, when no selector bit in 31..11 is set, address bits 15:11 are 5'b11111.
- R6: Each data-window access produces exactly one request cycle, which carries the access's write/read flag. The byte enables depend on the size code: size 0 gives 4'b0001, size 1 gives 4'b0011, and sizes 2 and 3 give 4'b1111. This mask is shifted left by offset[1:0] and kept to 4 bits. Write data is shifted left by 8×offset[1:0].
- R7: The CPU acknowledge for a data access is a one-cycle pulse. It comes in the cycle after the response is accepted, never earlier. The read data is the response shifted right by 8×offset[1:0] and masked to the size.
- R8: Pin p (0..3) of slot s belongs to device number SLOT_BASE+s. It drives controller input PIC_BASE + ((SLOT_BASE+s+p) mod 4). Each controller input is the OR of every pin routed to it, and all other controller inputs stay 0.
- R9: Data-window accesses leave the selector register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access strobe, only when no access is pending |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel_data | input | 1 | 0 = index region, 1 = data window |
| cpu_off | input | 3 | Low bits of the byte offset inside the region |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| cpu_wdata | input | 32 | Right-justified write data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Right-justified read data, valid with cpu_ack |
| cfg_req_valid | output | 1 | Configuration request strobe |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 32 | Translated configuration address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-placed write data |
| cfg_rsp_valid | input | 1 | Response strobe |
| cfg_rsp_data | input | 32 | Response word (lane-placed) |
| dev_irq | input | 4×NUM_SLOTS | Pin p of slot s at bit 4s+p |
| pic_irq | output | PIC_W | Interrupt-controller inputs |

## Verification
The bench builds the block with its defaults:

- **NUM_SLOTS = 4 and SLOT_BASE = 11:** the four consecutive device numbers 11 to 14 make every rotation of the pin-to-line mapping appear. Driving all sixteen slot/pin pairs one at a time therefore covers every line for every pin.
- **PIC_BASE = 27 and PIC_W = 32:** the routed lines sit at controller inputs 27..30, so bits both below and above them can be checked to stay quiet.

The translation checks cover all three selector modes, several one-hot patterns (single and multiple set bits, the highest usable bit) and the empty one-hot selector. Byte enables and lane placement are checked on byte, halfword and word accesses at non-zero offsets.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int WORD_W  = 32;
    localparam int BE_W    = WORD_W / 8;
    localparam int DEV_LSB = 11;
    localparam int DEV_W   = 5;
    localparam int PINS    = 4;

    typedef enum logic [1:0] {
        XL_PASS   = 2'd0,
        XL_TYPE1  = 2'd1,
        XL_ONEHOT = 2'd2
    } xl_mode_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        xl_mode_e          mode;
    } xl_result_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } acc_state_e;

    typedef struct packed {
        logic              we;
        logic [1:0]        size;
        logic [2:0]        off3;
        logic [WORD_W-1:0] wdata;
    } acc_cmd_t;

    function automatic logic [BE_W-1:0] lane_enables(logic [1:0] size, logic [1:0] lane);
        logic [BE_W-1:0] m;
        case (size)
            2'd0:    m = 4'b0001;
            2'd1:    m = 4'b0011;
            default: m = 4'b1111;
        endcase
        return m << lane;
    endfunction

    function automatic logic [WORD_W-1:0] lane_place(logic [WORD_W-1:0] d, logic [1:0] lane);
        return d << {lane, 3'b000};
    endfunction

    function automatic logic [WORD_W-1:0] lane_extract(logic [WORD_W-1:0] d, logic [1:0] lane,
                                                       logic [1:0] size);
        logic [WORD_W-1:0] s;
        s = d >> {lane, 3'b000};
        case (size)
            2'd0:    return {24'h0, s[7:0]};
            2'd1:    return {16'h0, s[15:0]};
            default: return s;
        endcase
    endfunction

    function automatic logic [DEV_W-1:0] lowest_slot_bit(logic [WORD_W-1:0] w);
        logic [DEV_W-1:0] pos;
        pos = '1;
        for (int i = WORD_W - 1; i >= DEV_LSB; i--) begin
            if (w[i]) pos = DEV_W'(i);
        end
        return pos;
    endfunction

endpackage

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate
    import cfgx_pkg::*;
(
    input  logic [WORD_W-1:0] sel_word,
    input  logic [2:0]        off3,
    output xl_result_t        res
);
    logic [DEV_W-1:0] dev_num;

    always_comb dev_num = lowest_slot_bit(sel_word);

    always_comb begin
        if (sel_word[WORD_W-1]) begin
            res.mode = XL_PASS;
            res.addr = sel_word | {{(WORD_W-2){1'b0}}, off3[1:0]};
        end else if (sel_word[0]) begin
            res.mode = XL_TYPE1;
            res.addr = {sel_word[WORD_W-1:3], off3};
        end else begin
            res.mode = XL_ONEHOT;
            res.addr = {{(WORD_W-DEV_LSB-DEV_W){1'b0}}, dev_num, sel_word[DEV_LSB-1:3], off3};
        end
    end

    always_comb begin
        if (res.mode == XL_ONEHOT && sel_word[DEV_LSB +: 4] == 4'b0001)
            assert_onehot_low_slot_R4: assert (res.addr[15:11] == 5'd11);
    end
endmodule

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] sel_q
);
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                sel_q[8*b +: 8] <= 8'h00;
            else if (wr_en && wr_be[b])
                sel_q[8*b +: 8] <= wr_data[8*b +: 8];
        end
    end
endmodule

// File: rtl/cfgx_access_fsm.sv
module cfgx_access_fsm
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_sel_data,
    input  logic [2:0]        cpu_off,
    input  logic [1:0]        cpu_size,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic [WORD_W-1:0] sel_q,
    output logic              idx_wr_en,
    output logic [BE_W-1:0]   idx_wr_be,
    output logic [WORD_W-1:0] idx_wr_data,
    output acc_cmd_t          cmd_q,
    output logic              busy,
    output logic              req_valid,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              cpu_ack,
    output logic [WORD_W-1:0] cpu_rdata
);
    acc_state_e state_q;
    logic       is_data_q;

    always_comb begin
        idx_wr_en   = (state_q == ST_IDLE) && cpu_req && !cpu_sel_data && cpu_we;
        idx_wr_be   = lane_enables(cpu_size, cpu_off[1:0]);
        idx_wr_data = lane_place(cpu_wdata, cpu_off[1:0]);
        req_valid   = (state_q == ST_ISSUE);
        cpu_ack     = (state_q == ST_DONE);
        busy        = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            is_data_q <= 1'b0;
            cmd_q     <= '0;
            cpu_rdata <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_req) begin
                    cmd_q     <= '{we: cpu_we, size: cpu_size, off3: cpu_off, wdata: cpu_wdata};
                    is_data_q <= cpu_sel_data;
                    if (cpu_sel_data) begin
                        state_q <= ST_ISSUE;
                    end else begin
                        cpu_rdata <= cpu_we ? '0 : lane_extract(sel_q, cpu_off[1:0], cpu_size);
                        state_q   <= ST_DONE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    cpu_rdata <= cmd_q.we ? '0 : lane_extract(rsp_data, cmd_q.off3[1:0], cmd_q.size);
                    state_q   <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_ack_after_rsp_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && is_data_q) |-> $past(rsp_valid));
    assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);
    assert_single_req_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid);
endmodule

// File: rtl/cfgx_irq_swizzle.sv
module cfgx_irq_swizzle
    import cfgx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_BASE = 11,
    parameter int PIC_W     = 32,
    parameter int PIC_BASE  = 27
) (
    input  logic [PINS*NUM_SLOTS-1:0] dev_irq,
    output logic [PIC_W-1:0]          pic_irq
);
    localparam int NPIN = PINS * NUM_SLOTS;

    function automatic logic [NPIN-1:0] line_mask(int line);
        logic [NPIN-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            for (int p = 0; p < PINS; p++)
                if (((SLOT_BASE + s + p) % PINS) == line) m[s*PINS + p] = 1'b1;
        return m;
    endfunction

    logic [PINS-1:0] line_lvl;

    for (genvar l = 0; l < PINS; l++) begin : g_line
        assign line_lvl[l] = |(dev_irq & line_mask(l));
    end

    always_comb begin
        pic_irq = '0;
        pic_irq[PIC_BASE +: PINS] = line_lvl;
    end

    always_comb begin
        if (dev_irq == '0)
            assert_irq_quiet_R8: assert (pic_irq == '0);
    end
endmodule

// File: rtl/cfg_xlate_bridge.sv
module cfg_xlate_bridge
    import cfgx_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_BASE = 11,
    parameter int PIC_W     = 32,
    parameter int PIC_BASE  = 27
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cpu_req,
    input  logic                           cpu_we,
    input  logic                           cpu_sel_data,
    input  logic [2:0]                     cpu_off,
    input  logic [1:0]                     cpu_size,
    input  logic [31:0]                    cpu_wdata,
    output logic                           cpu_ack,
    output logic [31:0]                    cpu_rdata,
    output logic                           cfg_req_valid,
    output logic                           cfg_we,
    output logic [31:0]                    cfg_addr,
    output logic [3:0]                     cfg_be,
    output logic [31:0]                    cfg_wdata,
    input  logic                           cfg_rsp_valid,
    input  logic [31:0]                    cfg_rsp_data,
    input  logic [4*NUM_SLOTS-1:0]         dev_irq,
    output logic [PIC_W-1:0]               pic_irq
);
    logic [WORD_W-1:0] sel_q;
    logic              idx_wr_en;
    logic [BE_W-1:0]   idx_wr_be;
    logic [WORD_W-1:0] idx_wr_data;
    acc_cmd_t          cmd_q;
    logic              busy;
    xl_result_t        xl;

    cfgx_index_reg u_index (
        .clk(clk), .rst(rst), .wr_en(idx_wr_en), .wr_be(idx_wr_be),
        .wr_data(idx_wr_data), .sel_q(sel_q)
    );

    cfgx_access_fsm u_fsm (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_sel_data(cpu_sel_data), .cpu_off(cpu_off), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .sel_q(sel_q), .idx_wr_en(idx_wr_en),
        .idx_wr_be(idx_wr_be), .idx_wr_data(idx_wr_data), .cmd_q(cmd_q),
        .busy(busy), .req_valid(cfg_req_valid), .rsp_valid(cfg_rsp_valid),
        .rsp_data(cfg_rsp_data), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata)
    );

    cfgx_addr_xlate u_xlate (
        .sel_word(sel_q), .off3(cmd_q.off3), .res(xl)
    );

    cfgx_irq_swizzle #(
        .NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE),
        .PIC_W(PIC_W), .PIC_BASE(PIC_BASE)
    ) u_irq (
        .dev_irq(dev_irq), .pic_irq(pic_irq)
    );

    always_comb begin
        cfg_addr  = xl.addr;
        cfg_we    = cmd_q.we;
        cfg_be    = lane_enables(cmd_q.size, cmd_q.off3[1:0]);
        cfg_wdata = lane_place(cmd_q.wdata, cmd_q.off3[1:0]);
    end

    assert_sel_stable_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(sel_q));
    assert_be_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_req_valid |-> (cfg_be != 4'b0000));
    assert_pass_keeps_top_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_req_valid && xl.mode == XL_PASS) |-> cfg_addr[31]);
endmodule

// File: tb/cfg_xlate_bridge_tb_top.sv
module cfg_xlate_bridge_tb_top;
    localparam int NS = 4, SB = 11, PW = 32, PB = 27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 0, cpu_we = 0, cpu_sel_data = 0;
    logic [2:0] cpu_off = 0;
    logic [1:0] cpu_size = 0;
    logic [31:0] cpu_wdata = 0;
    logic cpu_ack;
    logic [31:0] cpu_rdata;
    logic cfg_req_valid, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [3:0] cfg_be;
    logic cfg_rsp_valid = 0;
    logic [31:0] cfg_rsp_data = 0;
    logic [4*NS-1:0] dev_irq = 0;
    logic [PW-1:0] pic_irq;

    int checks = 0, failures = 0, cycles = 0;

    always #2.5 clk = ~clk;

    cfg_xlate_bridge #(.NUM_SLOTS(NS), .SLOT_BASE(SB), .PIC_W(PW), .PIC_BASE(PB)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_sel_data(cpu_sel_data), .cpu_off(cpu_off), .cpu_size(cpu_size),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .cfg_req_valid(cfg_req_valid), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rsp_valid(cfg_rsp_valid),
        .cfg_rsp_data(cfg_rsp_data), .dev_irq(dev_irq), .pic_irq(pic_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural models
    function automatic int be_model(int size, int off);
        int bytes = (size == 0) ? 1 : (size == 1) ? 2 : 4;
        int m = 0;
        for (int i = 0; i < bytes; i++) if (off + i < 4) m |= (1 << (off + i));
        return m;
    endfunction

    function automatic logic [31:0] rd_model(logic [31:0] w, int size, int off);
        logic [31:0] s = w >> (8 * off);
        if (size == 0) return s & 32'hFF;
        if (size == 1) return s & 32'hFFFF;
        return s;
    endfunction

    function automatic logic [31:0] addr_model(logic [31:0] sel, int off);
        int dev = 31;
        if (sel[31]) return sel | (off & 3);
        if (sel[0]) return (sel & ~32'h7) | off;
        for (int i = 31; i >= 11; i--) if (sel[i]) dev = i;
        return (dev << 11) | (sel & 32'h7F8) | off;
    endfunction

    function automatic logic [31:0] pic_model(logic [4*NS-1:0] pins);
        logic [31:0] r = 0;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (pins[s*4+p]) r[PB + ((SB + s + p) % 4)] = 1'b1;
        return r;
    endfunction

    // per-clock comparison of interrupt routing (R8)
    always @(negedge clk) begin
        cycles++;
        if (!rst) check("R8 per-clock routing", pic_irq, pic_model(dev_irq));
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idx_access(input logic we, input int off, input int size,
                              input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_sel_data = 0; cpu_off = 3'(off);
        cpu_size = 2'(size); cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        check("R1 index ack", {31'b0, cpu_ack}, 32'd1);
        rd = cpu_rdata;
    endtask

    task automatic data_access(input string req, input logic we, input int off, input int size,
                               input logic [31:0] wd, input logic [31:0] rsp,
                               input logic [31:0] exp_addr, output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_sel_data = 1; cpu_off = 3'(off);
        cpu_size = 2'(size); cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
        while (!cfg_req_valid && n < 10) begin @(negedge clk); n++; end
        check({req, " addr"}, cfg_addr, exp_addr);
        check("R6 byte enables", {28'b0, cfg_be}, 32'(be_model(size, off & 3)));
        check("R6 we", {31'b0, cfg_we}, {31'b0, we});
        if (we) check("R6 write lanes", cfg_wdata, wd << (8 * (off & 3)));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 single request", {31'b0, cfg_req_valid}, 32'd0);
            check("R7 no early ack", {31'b0, cpu_ack}, 32'd0);
        end
        cfg_rsp_valid = 1; cfg_rsp_data = rsp;
        @(negedge clk);
        cfg_rsp_valid = 0;
        check("R7 ack after response", {31'b0, cpu_ack}, 32'd1);
        rd = cpu_rdata;
        if (!we) check("R7 read data", rd, rd_model(rsp, size, off & 3));
        @(negedge clk);
        check("R7 ack one cycle", {31'b0, cpu_ack}, 32'd0);
    endtask

    task automatic set_sel(input logic [31:0] v);
        logic [31:0] d;
        idx_access(1, 0, 2, v, d);
    endtask

    initial begin
        logic [31:0] rd;
        logic [31:0] sel;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset value and readback
        idx_access(0, 0, 2, 0, rd);
        check("R1 reset selector", rd, 32'h0);
        idx_access(1, 1, 0, 32'hC3, rd);
        idx_access(0, 0, 2, 0, rd);
        check("R1 byte write", rd, 32'h0000C300);
        set_sel(32'h1234ABCD);
        idx_access(0, 2, 1, 0, rd);
        check("R1 half read", rd, 32'h1234);
        idx_access(0, 0, 2, 0, rd);
        check("R1 word read", rd, 32'h1234ABCD);

        // R2 pass-through mode
        sel = 32'h80ABCD10;
        set_sel(sel);
        data_access("R2", 0, 7, 0, 0, 32'h11223344, addr_model(sel, 7), rd);
        data_access("R2", 1, 2, 1, 32'hBEEF, 0, addr_model(sel, 2), rd);

        // R3 type-1 style
        sel = 32'h00ABCD15;
        set_sel(sel);
        data_access("R3", 0, 2, 1, 0, 32'hBEEF1234, addr_model(sel, 2), rd);
        data_access("R3", 1, 5, 0, 32'h5A, 0, addr_model(sel, 5), rd);

        // R4 one-hot mode, several patterns
        sel = (32'h1 << 13) | (32'h2 << 8) | 32'hA8;
        set_sel(sel);
        data_access("R4", 0, 6, 0, 0, 32'hDEADBEEF, (32'd13 << 11) | (32'h2 << 8) | 32'hA8 | 32'd6, rd);
        sel = (32'h1 << 20) | (32'h1 << 15) | 32'h7F0;
        set_sel(sel);
        data_access("R4", 1, 0, 2, 32'hCAFEF00D, 0, addr_model(sel, 0), rd);
        sel = (32'h1 << 30) | 32'h100;
        set_sel(sel);
        data_access("R4", 0, 3, 2, 0, 32'h89ABCDEF, addr_model(sel, 3), rd);
        sel = 32'h1 << 11;
        set_sel(sel);
        data_access("R4", 0, 1, 0, 0, 32'h0000AA00, (32'd11 << 11) | 32'd1, rd);

        // R5 empty one-hot
        sel = 32'h00000700;
        set_sel(sel);
        data_access("R5", 0, 4, 0, 0, 32'h77, (32'd31 << 11) | (32'h7 << 8) | 32'd4, rd);

        // R9 selector untouched by data accesses
        idx_access(0, 0, 2, 0, rd);
        check("R9 selector unchanged", rd, 32'h00000700);

        // R8 every slot/pin pair, one at a time, then a mixture
        for (int s = 0; s < NS; s++) begin
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                dev_irq = '0;
                dev_irq[s*4+p] = 1'b1;
                #1;
                check("R8 pair routing", pic_irq, 32'h1 << (PB + ((SB + s + p) % 4)));
            end
        end
        @(negedge clk);
        dev_irq = 16'h8421;
        #1;
        check("R8 mixed pins", pic_irq, pic_model(16'h8421));
        @(negedge clk);
        dev_irq = '0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule